// File: doc/BRIEF.md
# Bit-Plane Display Scanner

This block refreshes a multiplexed 4 by 8 digit array with eight segment lines per digit (seven bars and a dot). Brightness is produced with binary-weighted bit planes: each plane of the frame is shown for a time proportional to its binary weight. The block walks the planes of one segment, then moves to the next segment, and after the eighth segment one frame is done. For every plane it reads one 32-bit word from an external frame memory and shifts it out to a chain of shift registers as two 16-bit transfers, then strobes a latch. Whenever the segment changes it first sends a 16-bit control word that drives one segment line low (through a fixed line permutation) and carries a global brightness bit and a few status-lamp bits.

The number of active planes and the brightness bit are inputs that take effect only at a frame boundary. At every frame boundary the block measures the frame duration in microseconds and turns it into a frame rate in thousandths of a frame per second, using a small sequential divider. The hold time of the current plane is presented on its own output.

Top module: `bcm_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it, `sclk`, `latch`, `mem_rd_en` and `frame_tick` are 0, and `frame_us` and `frame_rate` read 0.
- R2: Each step moves to the next plane; once the next plane index is not below the active plane count the plane index returns to 0 and the segment index advances; after segment 7 the segment index returns to 0 and `frame_tick` pulses for one cycle. The first step after reset shows plane 1 of segment 0, so the first frame carries one data word fewer than a full frame.
- R3: Each step issues exactly one single-cycle memory read at address plane × 8 + segment; the read data is taken in the cycle after `mem_rd_en`.
- R4: A data word leaves as 32 bits, most significant bit first (upper 16-bit half, then lower half); `sdo` is valid while `sclk` is high, `sclk` is high for one cycle per bit, and `latch` pulses for one cycle, with `sclk` low, after the last bit.
- R5: Before the first data word of each segment (and before the very first data word after reset) a separate 16-bit control word is sent and latched: bit 0 is the brightness bit, bits 4:1 are `status_led[3:0]`, bits 7:5 are 0, bits 15:8 are all ones except bit 8+m, where m is the segment index mapped through the table 0→5, 1→7, 2→6, 3→4, 4→1, 5→3, 6→0, 7→2.
- R6: After a data latch, `hold_cycles` equals BASE_CYCLES shifted left by the plane index of that word, and no serial clock edge follows for more than that many cycles.
- R7: The active plane count and the brightness bit are sampled only when a frame wraps; after reset they are 10 planes and low brightness. The status bits are taken fresh for each control word.
- R8: A requested plane count of 0 is used as 1, and a count above 10 is used as 10.
- R9: The cycle after a frame wrap, `frame_us` holds the cycles between this wrap and the previous one divided by TICKS_PER_US, rounded down; the first wrap after reset only starts the measurement and leaves `frame_us` at 0.
- R10: `frame_rate` becomes 10^9 / `frame_us` within 40 cycles of a new measurement, stays 0 until the first measurement, is 0 when the measured time is 0, and never exceeds 10^9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| plane_count | input | 4 | Requested number of active bit planes |
| bright_hi | input | 1 | Requested global brightness level |
| status_led | input | LED_W (4) | Status-lamp bits placed in the control word |
| mem_rd_en | output | 1 | Frame-memory read strobe |
| mem_addr | output | 7 | Frame-memory word address |
| mem_rdata | input | 32 | Frame-memory read data, valid the cycle after the strobe |
| sdo | output | 1 | Serial data to the shift-register chain |
| sclk | output | 1 | Serial shift clock |
| latch | output | 1 | Shift-register output latch strobe |
| hold_cycles | output | 15 | Display time of the current plane in clock cycles |
| frame_tick | output | 1 | One-cycle pulse at every frame wrap |
| frame_us | output | 32 | Last measured frame duration in microseconds |
| frame_rate | output | 32 | Frame rate in thousandths of a frame per second |

## Verification
The assertions watch, on every cycle, the shape of the serial interface (one-cycle clock pulses, a latch only while the clock is low, single-cycle latches and reads), the memory address range, the binary weighting of the hold time, the single-cycle frame pulse, the stability of the measured frame time between wraps and the upper bound on the rate. Only the bench's scenarios can show the plane and segment order, the control-word contents and permutation, the clamping and frame-boundary sampling of the settings, the exact frame time and the divider result, because those need a reference model of the whole scan and of the elapsed cycles.

// File: rtl/scan_pkg.sv
// Shared types and helpers for the bit-plane display scanner.
// Assumes eight segment lines per digit; the line permutation is fixed.
package scan_pkg;

    typedef enum logic [3:0] {
        S_ADV,
        S_DEC,
        S_AUX_GO,
        S_AUX_WT,
        S_AUX_LAT,
        S_RD,
        S_CAP,
        S_HI_GO,
        S_HI_WT,
        S_LO_GO,
        S_LO_WT,
        S_DAT_LAT,
        S_HOLD
    } scan_state_e;

    // Maps a logical segment index to the physical driver line.
    function automatic logic [2:0] seg_line(input logic [2:0] seg);
        case (seg)
            3'd0:    seg_line = 3'd5;
            3'd1:    seg_line = 3'd7;
            3'd2:    seg_line = 3'd6;
            3'd3:    seg_line = 3'd4;
            3'd4:    seg_line = 3'd1;
            3'd5:    seg_line = 3'd3;
            3'd6:    seg_line = 3'd0;
            default: seg_line = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/plane_seq_ctr.sv
// Plane and segment counters for the scanner.
// Each step advances the plane; a plane wrap advances the segment; a segment
// wrap ends the frame and loads the frame-level settings (clamped plane count
// and brightness). Assumes planes_in is stable around a frame wrap.
module plane_seq_ctr #(
    parameter int MAX_PLANES = 10,
    parameter int NUM_SEG    = 8,
    localparam int BW = $clog2(MAX_PLANES),
    localparam int SW = $clog2(NUM_SEG),
    localparam int CW = $clog2(MAX_PLANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] planes_in,
    input  logic          bright_in,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] seg_idx,
    output logic          aux_due,
    output logic          frame_wrap,
    output logic          bright_q
);

    logic [CW-1:0] planes_q;
    logic [CW-1:0] planes_clamped;
    logic [CW-1:0] next_bit;
    logic          bit_wrap;
    logic          seg_last;
    logic          first_q;

    // Clamp the requested plane count into 1..MAX_PLANES.
    always_comb begin
        if (planes_in == '0)
            planes_clamped = CW'(1);
        else if (planes_in > CW'(MAX_PLANES))
            planes_clamped = CW'(MAX_PLANES);
        else
            planes_clamped = planes_in;
    end

    assign next_bit   = CW'(bit_idx) + CW'(1);
    assign bit_wrap   = (next_bit >= planes_q);
    assign seg_last   = (seg_idx == SW'(NUM_SEG - 1));
    assign frame_wrap = step && bit_wrap && seg_last;

    // Advance the counters on each step and reload settings at frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            seg_idx  <= '0;
            first_q  <= 1'b1;
            aux_due  <= 1'b0;
            planes_q <= CW'(MAX_PLANES);
            bright_q <= 1'b0;
        end else if (step) begin
            first_q <= 1'b0;
            aux_due <= first_q || bit_wrap;
            if (bit_wrap) begin
                bit_idx <= '0;
                if (seg_last) begin
                    seg_idx  <= '0;
                    planes_q <= planes_clamped;
                    bright_q <= bright_in;
                end else begin
                    seg_idx <= seg_idx + SW'(1);
                end
            end else begin
                bit_idx <= next_bit[BW-1:0];
            end
        end
    end

endmodule

// File: rtl/word_shifter.sv
// Serialises one XW-bit transfer, most significant bit first.
// Each bit takes two cycles: data set up with the clock low, then clock high.
// A start is accepted only while idle; 'last' marks the final clock-high cycle.
module word_shifter #(
    parameter int XW = 16,
    localparam int CNW = $clog2(XW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] din,
    output logic          sdo,
    output logic          sclk,
    output logic          last
);

    logic [XW-1:0]  sr;
    logic [CNW-1:0] cnt;
    logic           phase;
    logic           busy;

    assign sdo  = sr[XW-1];
    assign sclk = busy && phase;
    assign last = busy && phase && (cnt == '0);

    // Load on start, then alternate clock phases and shift after each high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            cnt   <= '0;
            phase <= 1'b0;
            busy  <= 1'b0;
        end else if (start && !busy) begin
            sr    <= din;
            cnt   <= CNW'(XW - 1);
            phase <= 1'b0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                sr    <= sr << 1;
                if (cnt == '0)
                    busy <= 1'b0;
                else
                    cnt <= cnt - CNW'(1);
            end
        end
    end

endmodule

// File: rtl/frame_timer.sv
// Measures the time between frame wraps in whole microseconds.
// A prescaler divides the clock by TICKS_PER_US; both counters restart at
// every wrap. The first wrap after reset only arms the measurement.
module frame_timer #(
    parameter int TICKS_PER_US = 200,
    localparam int PSW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wrap,
    output logic [31:0] frame_us,
    output logic        cap_pulse
);

    logic [PSW-1:0] presc;
    logic [31:0]    us_cnt;
    logic           armed;
    logic           us_tick;

    assign us_tick = (presc == PSW'(TICKS_PER_US - 1));

    // Count microseconds and capture the count at each wrap once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc     <= '0;
            us_cnt    <= '0;
            armed     <= 1'b0;
            frame_us  <= '0;
            cap_pulse <= 1'b0;
        end else if (wrap) begin
            presc     <= '0;
            us_cnt    <= '0;
            armed     <= 1'b1;
            cap_pulse <= armed;
            if (armed)
                frame_us <= us_cnt + 32'(us_tick);
        end else begin
            cap_pulse <= 1'b0;
            if (us_tick) begin
                presc  <= '0;
                us_cnt <= us_cnt + 32'd1;
            end else begin
                presc <= presc + PSW'(1);
            end
        end
    end

endmodule

// File: rtl/rate_divider.sv
// Restoring divider: quotient = NUMER / divisor, one quotient bit per cycle.
// The previous result is held until a new division finishes; a zero divisor
// gives 0 at once. Assumes starts are spaced more than W cycles apart.
module rate_divider #(
    parameter int NUMER = 1000000000,
    parameter int W     = 32,
    localparam int CNW  = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient
);

    logic [W-1:0]   rem;
    logic [W-1:0]   dvd;
    logic [W-1:0]   dsr;
    logic [W-1:0]   quo;
    logic [CNW-1:0] cnt;
    logic           busy;
    logic [W:0]     rem_sh;
    logic           ge;
    logic [W-1:0]   rem_nx;
    logic [W-1:0]   quo_nx;

    // One restoring step: shift in a dividend bit, subtract when it fits.
    always_comb begin
        rem_sh = {rem, dvd[W-1]};
        ge     = (rem_sh >= {1'b0, dsr});
        rem_nx = ge ? (rem_sh[W-1:0] - dsr) : rem_sh[W-1:0];
        quo_nx = {quo[W-2:0], ge};
    end

    // Sequence the division and publish the quotient when the last bit lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            dvd      <= '0;
            dsr      <= '0;
            quo      <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            quotient <= '0;
        end else if (start) begin
            if (divisor == '0) begin
                busy     <= 1'b0;
                quotient <= '0;
            end else begin
                rem  <= '0;
                dvd  <= W'(NUMER);
                dsr  <= divisor;
                quo  <= '0;
                cnt  <= CNW'(W - 1);
                busy <= 1'b1;
            end
        end else if (busy) begin
            rem <= rem_nx;
            dvd <= dvd << 1;
            quo <= quo_nx;
            if (cnt == '0) begin
                busy     <= 1'b0;
                quotient <= quo_nx;
            end else begin
                cnt <= cnt - CNW'(1);
            end
        end
    end

endmodule

// File: rtl/bcm_scanner.sv
// Bit-plane multiplexed display scanner (top).
// Per step: advance plane/segment, send a control word if the segment
// changed, read one frame word, shift it out as two halves, latch, then hold
// for the plane's binary-weighted time. Assumes a frame memory with one
// cycle of read latency and one word per segment per plane.
module bcm_scanner #(
    parameter int ROWS         = 4,
    parameter int COLS         = 8,
    parameter int MAX_PLANES   = 10,
    parameter int LED_W        = 4,
    parameter int BASE_CYCLES  = 16,
    parameter int TICKS_PER_US = 200,
    parameter int WORD_W       = 32,
    localparam int NUM_SEG = 8,
    localparam int WPP     = ROWS * COLS * NUM_SEG / WORD_W,
    localparam int DEPTH   = MAX_PLANES * WPP,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(MAX_PLANES + 1),
    localparam int HW      = $clog2(BASE_CYCLES) + MAX_PLANES + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     plane_count,
    input  logic              bright_hi,
    input  logic [LED_W-1:0]  status_led,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              sdo,
    output logic              sclk,
    output logic              latch,
    output logic [HW-1:0]     hold_cycles,
    output logic              frame_tick,
    output logic [31:0]       frame_us,
    output logic [31:0]       frame_rate
);
    import scan_pkg::*;

    localparam int XW = WORD_W / 2;
    localparam int BW = $clog2(MAX_PLANES);
    localparam int SW = $clog2(NUM_SEG);

    scan_state_e   state, nxt;
    logic [BW-1:0] bit_idx;
    logic [SW-1:0] seg_idx;
    logic          aux_due;
    logic          bright_q;
    logic          step;
    logic [WORD_W-1:0] word_q;
    logic [HW-1:0] hold_cnt;
    logic [XW-1:0] aux_word;
    logic [XW-1:0] sh_din;
    logic          sh_start;
    logic          sh_last;
    logic          cap_pulse;
    logic [7:0]    line_sel_n;

    assign step = (state == S_ADV);

    plane_seq_ctr #(
        .MAX_PLANES(MAX_PLANES),
        .NUM_SEG   (NUM_SEG)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .planes_in (plane_count),
        .bright_in (bright_hi),
        .bit_idx   (bit_idx),
        .seg_idx   (seg_idx),
        .aux_due   (aux_due),
        .frame_wrap(frame_tick),
        .bright_q  (bright_q)
    );

    // Active-low one-hot line select and the control word around it.
    always_comb begin
        line_sel_n = ~(8'h01 << seg_line(seg_idx));
        aux_word   = XW'({line_sel_n, 8'({status_led, bright_q})});
    end

    // Pick the transfer for the shifter from the current state.
    always_comb begin
        sh_start = 1'b0;
        sh_din   = word_q[WORD_W-1:XW];
        case (state)
            S_AUX_GO: begin sh_start = 1'b1; sh_din = aux_word;          end
            S_HI_GO:  begin sh_start = 1'b1; sh_din = word_q[WORD_W-1:XW]; end
            S_LO_GO:  begin sh_start = 1'b1; sh_din = word_q[XW-1:0];    end
            default:  ;
        endcase
    end

    word_shifter #(.XW(XW)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .start(sh_start),
        .din  (sh_din),
        .sdo  (sdo),
        .sclk (sclk),
        .last (sh_last)
    );

    assign mem_rd_en   = (state == S_RD);
    assign mem_addr    = AW'(bit_idx) * AW'(WPP) + AW'(seg_idx);
    assign latch       = (state == S_AUX_LAT) || (state == S_DAT_LAT);
    assign hold_cycles = HW'(BASE_CYCLES) << bit_idx;

    // Step sequence: advance, optional control word, read, two halves, hold.
    always_comb begin
        nxt = state;
        case (state)
            S_ADV:     nxt = S_DEC;
            S_DEC:     nxt = aux_due ? S_AUX_GO : S_RD;
            S_AUX_GO:  nxt = S_AUX_WT;
            S_AUX_WT:  if (sh_last) nxt = S_AUX_LAT;
            S_AUX_LAT: nxt = S_RD;
            S_RD:      nxt = S_CAP;
            S_CAP:     nxt = S_HI_GO;
            S_HI_GO:   nxt = S_HI_WT;
            S_HI_WT:   if (sh_last) nxt = S_LO_GO;
            S_LO_GO:   nxt = S_LO_WT;
            S_LO_WT:   if (sh_last) nxt = S_DAT_LAT;
            S_DAT_LAT: nxt = S_HOLD;
            S_HOLD:    if (hold_cnt == '0) nxt = S_ADV;
            default:   nxt = S_ADV;
        endcase
    end

    // State register, captured frame word and hold countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_ADV;
            word_q   <= '0;
            hold_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == S_CAP)
                word_q <= mem_rdata;
            if (state == S_DAT_LAT)
                hold_cnt <= hold_cycles - HW'(1);
            else if (state == S_HOLD && hold_cnt != '0)
                hold_cnt <= hold_cnt - HW'(1);
        end
    end

    frame_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (frame_tick),
        .frame_us (frame_us),
        .cap_pulse(cap_pulse)
    );

    rate_divider #(.NUMER(1000000000), .W(32)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cap_pulse),
        .divisor (frame_us),
        .quotient(frame_rate)
    );

endmodule

// File: rtl/scan_checker.sv
// Interface and timing properties of the scanner, bound to the top module.
module scan_checker #(
    parameter int MAX_PLANES  = 10,
    parameter int BASE_CYCLES = 16,
    parameter int WPP         = 8,
    parameter int AW          = 7,
    parameter int HW          = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk,
    input logic          latch,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic [HW-1:0] hold_cycles,
    input logic          frame_tick,
    input logic [31:0]   frame_us,
    input logic [31:0]   frame_rate
);

    AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk); // R4
    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !sclk); // R4
    AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> !latch); // R4
    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R3
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < MAX_PLANES * WPP)); // R3
    AST_HOLD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hold_cycles) % BASE_CYCLES == 0)
        && $onehot(hold_cycles / HW'(BASE_CYCLES))); // R6
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick); // R2
    AST_US_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(frame_us)); // R9
    AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rate <= 32'd1000000000); // R10

endmodule

bind bcm_scanner scan_checker #(
    .MAX_PLANES (MAX_PLANES),
    .BASE_CYCLES(BASE_CYCLES),
    .WPP        (WPP),
    .AW         (AW),
    .HW         (HW)
) u_scan_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .latch      (latch),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .hold_cycles(hold_cycles),
    .frame_tick (frame_tick),
    .frame_us   (frame_us),
    .frame_rate (frame_rate)
);

// File: tb/bcm_scanner_tb.sv
// Scan-sequence bench: a reference model predicts every latched word, the
// per-frame word counts and the frame timing across plane-count sweeps.
module bcm_scanner_tb;

    localparam int BASE = 2;
    localparam int TPU  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  plane_in = 4'd3;
    logic        bright_in = 1'b1;
    logic [3:0]  led_in = 4'b1010;
    logic        mem_rd_en;
    logic [6:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        sdo, sclk, latch, frame_tick;
    logic [14:0] hold_cycles;
    logic [31:0] frame_us, frame_rate;

    always #2.5 clk = ~clk;

    bcm_scanner #(
        .BASE_CYCLES (BASE),
        .TICKS_PER_US(TPU)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .plane_count(plane_in), .bright_hi(bright_in),
        .status_led(led_in), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .sdo(sdo), .sclk(sclk), .latch(latch),
        .hold_cycles(hold_cycles), .frame_tick(frame_tick),
        .frame_us(frame_us), .frame_rate(frame_rate)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b ^ 8'h5A, ~b, b + 8'h33, 8'(a * 3) ^ 8'hC3};
    endfunction

    function automatic int line_of(input int s);
        case (s)
            0: return 5; 1: return 7; 2: return 6; 3: return 4;
            4: return 1; 5: return 3; 6: return 0; default: return 2;
        endcase
    endfunction

    function automatic int clampp(input int p);
        if (p == 0) return 1;
        if (p > 10) return 10;
        return p;
    endfunction

    // Memory with one cycle of read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rdata <= mem_word(int'(mem_addr));
    end

    // Reference model state.
    int m_bit = 0, m_seg = 0, m_planes = 10, m_first = 1;
    bit m_bright = 0;
    int q_len[2];
    logic [31:0] q_val[2];
    int q_cnt = 0, q_rd = 0, q_addr = 0, q_hold = 0;

    task automatic gen_step();
        int nb;
        bit segch;
        nb = m_bit + 1;
        segch = (m_first != 0);
        m_first = 0;
        if (nb >= m_planes) begin
            nb = 0;
            segch = 1;
            if (m_seg == 7) begin
                m_seg = 0;
                m_planes = clampp(int'(plane_in));
                m_bright = bright_in;
            end else m_seg++;
        end
        m_bit = nb;
        q_cnt = 0;
        q_rd  = 0;
        if (segch) begin
            q_len[0] = 16;
            q_val[0] = {16'h0, ~(8'h01 << line_of(m_seg)), 8'({led_in, m_bright})};
            q_cnt = 1;
        end
        q_len[q_cnt] = 32;
        q_val[q_cnt] = mem_word(m_bit * 8 + m_seg);
        q_cnt++;
        q_addr = m_bit * 8 + m_seg;
        q_hold = BASE << m_bit;
    endtask

    // Monitor state.
    logic        prev_sclk = 0;
    logic [31:0] sh = 0;
    int nbits = 0, last_addr = -1, data_total = 0, frame_data = 0;
    int ticks = 0, c1 = 0, c2 = 0, cur_planes = 10;
    bit hold_pend = 0;
    int lat_cyc = 0, gap_hold = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_rd_en) last_addr = int'(mem_addr);
            if (sclk && !prev_sclk) begin
                sh = {sh[30:0], sdo};
                nbits++;
                if (hold_pend) begin
                    chk(cyc - lat_cyc > gap_hold, "R6 hold gap", cyc - lat_cyc, gap_hold + 1);
                    hold_pend = 0;
                end
            end
            prev_sclk = sclk;
            if (latch) begin
                if (q_rd == q_cnt) gen_step();
                if (q_len[q_rd] == 16) begin
                    chk(nbits == 16 && sh == q_val[q_rd], "R5 R7 control word", sh, q_val[q_rd]);
                end else begin
                    chk(nbits == 32 && sh == q_val[q_rd], "R2 R4 R7 data word", sh, q_val[q_rd]);
                    chk(last_addr == q_addr, "R3 read address", last_addr, q_addr);
                    chk(int'(hold_cycles) == q_hold, "R6 hold value", hold_cycles, q_hold);
                    hold_pend = 1;
                    lat_cyc = cyc;
                    gap_hold = q_hold;
                    data_total++;
                    frame_data++;
                end
                q_rd++;
                nbits = 0;
                sh = 0;
            end
            if (frame_tick) begin
                int exp_words, exp_us;
                longint exp_rate;
                ticks++;
                exp_words = (ticks == 1) ? 79 : 8 * cur_planes;
                chk(frame_data == exp_words, "R2 R7 R8 words per frame", frame_data, exp_words);
                exp_us = (ticks >= 3) ? (c1 - c2) / TPU : 0;
                exp_rate = (ticks >= 3 && exp_us > 0) ? 64'd1000000000 / exp_us : 0;
                chk(int'(frame_us) == exp_us, "R9 frame time", frame_us, exp_us);
                chk(longint'(frame_rate) == exp_rate, "R10 frame rate", frame_rate, exp_rate);
                c2 = c1;
                c1 = cyc;
                cur_planes = clampp(int'(plane_in));
                frame_data = 0;
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        int target;
        target = ticks + n;
        while (ticks < target) @(negedge clk);
    endtask

    task automatic wait_data(input int n);
        int target;
        target = data_total + n;
        while (data_total < target) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ticks, 12);
            summary();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk(!sclk && !latch && !mem_rd_en && !frame_tick, "R1 controls in reset",
            {sclk, latch, mem_rd_en, frame_tick}, 0);
        chk(frame_us == 0 && frame_rate == 0, "R1 timing outputs in reset",
            frame_us ^ frame_rate, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk && !latch && !mem_rd_en, "R1 first cycle after reset",
            {sclk, latch, mem_rd_en}, 0);
        wait_ticks(3);
        wait_data(20);
        plane_in = 4'd0; bright_in = 1'b0; led_in = 4'b0101;
        wait_ticks(3);
        wait_data(3);
        plane_in = 4'd15; bright_in = 1'b1; led_in = 4'b0011;
        wait_ticks(2);
        wait_data(30);
        plane_in = 4'd2; bright_in = 1'b0; led_in = 4'b1111;
        wait_ticks(3);
        done = 1;
        summary();
    end

endmodule